// File: doc/BRIEF.md
# Packed pixel word unpacker

This block sits between a memory read stream and a pixel pipeline. It takes 32-bit words over a valid/ready handshake and emits one pixel per output beat, together with a tag that names the storage layout in use. Three layouts are handled. In the 32-bit layout each word is one pixel. In the 24-bit layout pixels are packed back to back, so three words carry four pixels and some pixels cross a word boundary. In the 16-bit layout each word carries two pixels, and the two bytes of each pixel are swapped in memory.

Bytes that a word leaves over are kept in a small byte buffer until the next word arrives. A line-start pulse throws away any leftover bytes, so every line begins on a fresh byte phase. The layout code may change only in a cycle where line start is high. Address generation, memory access and colour conversion belong to other blocks.

Top module: `pix_unpack`

## Requirements
- R1: With `fmt` = 2'b00, each accepted word yields exactly one pixel equal to the word: blue in bits 7:0, green in 15:8, red in 23:16 and alpha in 31:24.
- R2: With `fmt` = 2'b01, the bytes of the words are taken lowest byte first and three at a time, as blue, green, red. The pixel is {8'h00, red, green, blue}, so three words give exactly four pixels.
- R3: In the 24-bit layout a pixel may span two words. For example, pixel 1 of a group takes byte 3 of the first word and bytes 0 and 1 of the second word.
- R4: With `fmt` = 2'b10, each word yields two pixels, the even one from bits 15:0 first and then the odd one from bits 31:16. The output is {16'h0000, lower byte of the halfword, upper byte of the halfword}.
- R5: While `line_start` is high, `out_valid` is low and all stored bytes are discarded. A word accepted in that same cycle becomes byte 0 of the new line.
- R6: `in_ready` is high exactly when the buffer holds at most BUF_BYTES-4 bytes (4 of 8 with the default), so no word is ever dropped.
- R7: While `out_valid` is high and `out_ready` is low, the pixel holds steady. Pixels leave in stream order with none lost or repeated.
- R8: The reserved code `fmt` = 2'b11 unpacks like 2'b00, and `out_fmt` always reports the `fmt` input.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Start of line; flushes leftover bytes |
| fmt | input | 2 | Layout code: 00 32-bit, 01 24-bit, 10 16-bit, 11 reserved |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Room for one more word |
| in_word | input | 32 | Memory word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_pix | output | 32 | Unpacked pixel |
| out_fmt | output | 2 | Layout tag of the pixel |

## Verification
The bench goes after the 24-bit phase rotation over long streams. A design that mis-tracks the byte offset would send out pixels with shifted colour channels, starting from the first pixel that crosses a word boundary. It checks the 16-bit byte swap and halfword order; an error there shows up as swapped channels or pixels in the wrong order. Stalls on both sides check that a held pixel does not change and that the buffer refuses a third word. It also checks that a line start really discards leftover bytes: a design that kept them would emit stale bytes at the head of the next line.

// File: rtl/pu_pkg.sv
package pu_pkg;

   typedef enum logic [1:0] {
      PF_ARGB32 = 2'b00,
      PF_RGB24  = 2'b01,
      PF_RGB16  = 2'b10,
      PF_RSVD   = 2'b11
   } pix_fmt_e;

   // bytes consumed from the buffer for one pixel of the given layout
   function automatic logic [2:0] pix_bytes(input logic [1:0] f);
      case (f)
         PF_RGB24: pix_bytes = 3'd3;
         PF_RGB16: pix_bytes = 3'd2;
         default:  pix_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/pu_byte_buf.sv
module pu_byte_buf #(
   parameter int WORD_BYTES = 4,
   parameter int BUF_BYTES  = 8,
   parameter int CNT_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    push,
   input  logic [8*WORD_BYTES-1:0] word,
   input  logic                    pop,
   input  logic [2:0]              pop_n,
   output logic [CNT_W-1:0]        fill,
   output logic [8*WORD_BYTES-1:0] head
);
   localparam int BUF_W  = 8 * BUF_BYTES;
   localparam int WORD_W = 8 * WORD_BYTES;

   logic [BUF_W-1:0] mem_q, mem_d, shifted, ins, msk;
   logic [CNT_W-1:0] fill_q, fill_d, kept;
   logic [2:0]       sh;

   always_comb begin
      sh      = (pop && !clear) ? pop_n : 3'd0;
      kept    = clear ? '0 : (pop ? fill_q - CNT_W'(pop_n) : fill_q);
      shifted = mem_q >> {sh, 3'b000};
      ins     = BUF_W'(word) << {kept, 3'b000};
      msk     = BUF_W'({WORD_W{1'b1}}) << {kept, 3'b000};
      mem_d   = push ? ((shifted & ~msk) | ins) : shifted;
      fill_d  = kept + (push ? CNT_W'(WORD_BYTES) : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q  <= '0;
         fill_q <= '0;
      end else begin
         mem_q  <= mem_d;
         fill_q <= fill_d;
      end
   end

   assign fill = fill_q;
   assign head = mem_q[WORD_W-1:0];

endmodule

// File: rtl/pu_pix_pack.sv
module pu_pix_pack import pu_pkg::*; #(
   parameter int PIX_BYTES = 4
) (
   input  logic [1:0]             fmt,
   input  logic [8*PIX_BYTES-1:0] head,
   output logic [8*PIX_BYTES-1:0] pix
);
   for (genvar l = 0; l < PIX_BYTES; l++) begin : g_lane
      logic [7:0] lane;
      always_comb begin
         case (fmt)
            PF_RGB24: lane = (l < 3) ? head[8*l +: 8] : 8'h00;
            PF_RGB16: begin
               if (l == 0)      lane = head[15:8];
               else if (l == 1) lane = head[7:0];
               else             lane = 8'h00;
            end
            default:  lane = head[8*l +: 8];
         endcase
      end
      assign pix[8*l +: 8] = lane;
   end

endmodule

// File: rtl/pu_flow.sv
module pu_flow import pu_pkg::*; #(
   parameter int WORD_BYTES = 4,
   parameter int BUF_BYTES  = 8,
   parameter int CNT_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic [CNT_W-1:0] fill,
   input  logic [1:0]       fmt,
   input  logic             line_start,
   input  logic             in_valid,
   input  logic             out_ready,
   output logic             in_ready,
   output logic             out_valid,
   output logic             push,
   output logic             pop,
   output logic [2:0]       pop_n
);
   localparam int ROOM = BUF_BYTES - WORD_BYTES;

   always_comb begin
      pop_n     = pix_bytes(fmt);
      in_ready  = (fill <= CNT_W'(ROOM));
      out_valid = !line_start && (fill >= CNT_W'(pop_n));
      push      = in_valid && in_ready;
      pop       = out_valid && out_ready;
   end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack import pu_pkg::*; #(
   parameter int WORD_W    = 32,
   parameter int BUF_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [1:0]        fmt,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_pix,
   output logic [1:0]        out_fmt
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int CNT_W      = $clog2(BUF_BYTES + 1);

   if (WORD_W != 32) begin : g_bad_word
      $error("pix_unpack: WORD_W must be 32");
   end
   if (BUF_BYTES < 6) begin : g_bad_buf
      $error("pix_unpack: BUF_BYTES must be at least 6");
   end

   logic [CNT_W-1:0]  fill;
   logic [WORD_W-1:0] head;
   logic              push, pop;
   logic [2:0]        pop_n;

   pu_flow #(.WORD_BYTES(WORD_BYTES), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_flow (
      .fill(fill), .fmt(fmt), .line_start(line_start), .in_valid(in_valid),
      .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
      .push(push), .pop(pop), .pop_n(pop_n)
   );

   pu_byte_buf #(.WORD_BYTES(WORD_BYTES), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(line_start), .push(push), .word(in_word),
      .pop(pop), .pop_n(pop_n), .fill(fill), .head(head)
   );

   pu_pix_pack #(.PIX_BYTES(WORD_BYTES)) u_pack (
      .fmt(fmt), .head(head), .pix(out_pix)
   );

   assign out_fmt = fmt;

endmodule

// File: rtl/pu_chk.sv
module pu_chk #(
   parameter int BUF_BYTES = 8,
   parameter int CNT_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_start,
   input logic [1:0]       fmt,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [31:0]      out_pix,
   input logic [CNT_W-1:0] fill
);
   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(BUF_BYTES));

   // R6
   word_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !line_start && !out_valid) |=> fill == $past(fill) + CNT_W'(4));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (line_start || (out_valid && $stable(out_pix))));

   // R5
   line_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !(in_valid && in_ready)) |=> !out_valid);

   // R2
   pix24_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fmt == 2'b01) |-> out_pix[31:24] == 8'h00);

   // R4
   pix16_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fmt == 2'b10) |-> out_pix[31:16] == 16'h0000);

endmodule

bind pix_unpack pu_chk #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start), .fmt(fmt),
   .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_pix(out_pix), .fill(fill)
);

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;
   localparam int BUF = 8;

   logic        clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
   logic        in_valid = 1'b0, out_ready = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic [31:0] in_word = '0;
   logic        in_ready, out_valid;
   logic [31:0] out_pix;
   logic [1:0]  out_fmt;

   int checks = 0, errors = 0, cyc_total = 0;

   pix_unpack #(.WORD_W(32), .BUF_BYTES(BUF)) u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .fmt(fmt),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_fmt(out_fmt)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         errors++;
         $display("FAIL watchdog: run did not end");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] sb(input int seed, input int j);
      return 8'((j * 37 + seed * 59 + 13) % 256);
   endfunction

   function automatic logic [31:0] wd(input int seed, input int i);
      return {sb(seed, 4*i+3), sb(seed, 4*i+2), sb(seed, 4*i+1), sb(seed, 4*i)};
   endfunction

   function automatic int npix(input int f, input int nw);
      if (f == 1) return (nw * 4) / 3;
      if (f == 2) return nw * 2;
      return nw;
   endfunction

   function automatic logic [31:0] expix(input int f, input int seed, input int k);
      if (f == 1) return {8'h00, sb(seed, 3*k+2), sb(seed, 3*k+1), sb(seed, 3*k)};
      if (f == 2) return {16'h0000, sb(seed, 2*k), sb(seed, 2*k+1)};
      return wd(seed, k);
   endfunction

   function automatic string tag(input int f, input int k);
      if (f == 1) return ((k % 4 == 1) || (k % 4 == 2)) ? "R3" : "R2";
      if (f == 2) return "R4";
      if (f == 3) return "R8";
      return "R1";
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input int f, input int nw, input int seed, input int ip, input int op, input bit use_sol);
      int wi = 0, pi = 0, cyc = 0, np;
      bit hold = 1'b0;
      logic [31:0] held = '0;
      np = npix(f, nw);
      fmt = 2'(f);
      while (pi < np && cyc < 4000) begin
         @(negedge clk);
         line_start = use_sol && (cyc == 0);
         in_valid   = (wi < nw) && !(ip > 1 && (cyc % ip) == 0);
         in_word    = wd(seed, wi);
         out_ready  = !(op > 1 && (cyc % op) == 1);
         #1;
         if (line_start) chk(!out_valid, "R5", 32'(out_valid), 32'd0);
         if (hold) chk(out_valid && out_pix == held, "R7", out_pix, held);
         hold = out_valid && !out_ready;
         held = out_pix;
         if (out_valid && out_ready) begin
            chk(out_pix == expix(f, seed, pi), tag(f, pi), out_pix, expix(f, seed, pi));
            chk(out_fmt == 2'(f), "R8", 32'(out_fmt), 32'(f));
            pi++;
         end
         if (in_valid && in_ready) wi++;
         cyc++;
      end
      if (pi < np) chk(1'b0, "R7", 32'(pi), 32'(np));
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0; line_start = 1'b0;
   endtask

   initial begin
      int acc;
      repeat (3) @(negedge clk);
      #1;
      // R9: state held in reset
      chk(!out_valid, "R9", 32'(out_valid), 32'd0);
      chk(in_ready, "R9", 32'(in_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!out_valid && in_ready, "R9", {30'd0, out_valid, in_ready}, 32'd1);

      // R1: 32-bit layout, free flowing and throttled
      run(0, 8, 1, 1, 1, 1'b1);
      run(0, 12, 2, 3, 4, 1'b1);
      // R2 / R3: 24-bit layout over several phases and stall patterns
      run(1, 12, 3, 1, 1, 1'b1);
      run(1, 9, 4, 2, 3, 1'b1);
      run(1, 15, 5, 4, 2, 1'b1);
      // R4: 16-bit layout
      run(2, 10, 6, 1, 1, 1'b1);
      run(2, 7, 7, 3, 2, 1'b1);
      // R8: reserved code behaves as 32-bit
      run(3, 5, 8, 1, 2, 1'b1);

      // R5: one leftover byte, then a new line whose first word arrives with line_start
      run(1, 1, 9, 1, 1, 1'b1);
      run(1, 3, 10, 1, 1, 1'b1);

      // R5: a pending pixel is withdrawn and flushed by line_start
      @(negedge clk);
      fmt = 2'b00; line_start = 1'b1; in_valid = 1'b1; in_word = wd(12, 0); out_ready = 1'b0;
      @(negedge clk);
      line_start = 1'b0; in_valid = 1'b0; #1;
      chk(out_valid && out_pix == wd(12, 0), "R5", out_pix, wd(12, 0));
      @(negedge clk);
      line_start = 1'b1; out_ready = 1'b1; #1;
      chk(!out_valid, "R5", 32'(out_valid), 32'd0);
      @(negedge clk);
      line_start = 1'b0; #1;
      chk(!out_valid && in_ready, "R5", {30'd0, out_valid, in_ready}, 32'd1);
      out_ready = 1'b0;
      // R5: 24-bit stream without line_start after the flush starts on fresh bytes
      run(1, 3, 13, 1, 1, 1'b0);

      // R6: input stalls once the buffer cannot take another word
      @(negedge clk);
      fmt = 2'b00; line_start = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      line_start = 1'b0;
      acc = 0;
      for (int c = 0; c < 4; c++) begin
         in_valid = 1'b1; in_word = wd(20, acc); #1;
         chk(in_ready == (acc * 4 <= BUF - 4), "R6", 32'(in_ready), 32'(acc * 4 <= BUF - 4));
         if (in_ready) acc++;
         @(negedge clk);
      end
      in_valid = 1'b0; out_ready = 1'b1;
      for (int k = 0; k < 2; k++) begin
         #1;
         chk(out_valid && out_pix == wd(20, k), "R6", out_pix, wd(20, k));
         @(negedge clk);
      end
      out_ready = 1'b0; #1;
      chk(in_ready && !out_valid, "R6", {30'd0, out_valid, in_ready}, 32'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule